// File: doc/BRIEF.md
# Triggered drift-time readout core

The block takes one 8-bit word per channel on each bunch clock for 16 channels. Each bit of a word is one 3.125 ns slice of the 25 ns period, and bit 0 is the earliest slice. Every word is written into a circular sample memory. When a level-1 accept arrives, the block copies three consecutive words per channel from a programmable depth of that memory. These are the triggered bunch and the bunches on either side of it. An 8-bit bunch-counter time stamp is attached, and the result goes into a derandomizing buffer of 13 pending events.

A serializer drains the buffer onto a single output bit, one bit per clock. Frames can follow each other with no gap, and new accepts keep arriving while a frame is being sent. If an accept arrives while the buffer is full, that event is lost. The loss is flagged in the error bit of the next frame that starts.

Top module: `drift_readout_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sdo` is 0. The bunch counter is 0 in the cycle in which `rst` is first low.
- R2: The bunch counter advances by one every clock and wraps modulo 256. Asserting `bcr` in cycle c makes the counter 0 in cycle c+1. The time stamp of an event is the counter value in the cycle of its accept.
- R3: An accept in cycle t with latency value L (1 to 255) captures, per channel, the words presented in cycles t-L-1, t-L and t-L+1, in that order. `lat` must be held from cycle t to cycle t+1.
- R4: A frame is sent in this order: a start bit 1, the 8 time-stamp bits MSB first, and the error bit. Then come 384 data bits ordered by channel 0 to 15, within a channel by sample (earliest first), and within a sample by bit 0 to bit 7. That makes 394 bits in total.
- R5: An accept in cycle t that finds the buffer empty and the serializer idle puts its start bit on `sdo` in cycle t+3. The remaining bits follow on consecutive cycles.
- R6: If another event is pending when a frame's last bit is on `sdo`, the next start bit follows in the very next cycle. Consecutive frame starts are therefore exactly 394 cycles apart.
- R7: The buffer holds up to 13 pending events in addition to the frame being sent. An accept whose event would be stored while 13 events are pending, and while no frame starts at that edge, is dropped and never transmitted.
- R8: A dropped event sets a sticky overflow flag. The flag is sent as error bit 1 in the next frame to start and is then cleared. Frames with no drop before them carry error bit 0.
- R9: `sdo` is 0 whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| bcr | input | 1 | Synchronous bunch-counter reset |
| l1a | input | 1 | Level-1 accept, one cycle per event |
| lat | input | 8 | Trigger latency in clocks, 1 to 255 |
| din | input | 128 | Sample words, channel n in bits 8n+7 down to 8n |
| sdo | output | 1 | Serial event stream |

## Verification
An accept in cycle t is captured at the edge closing cycle t+1 and stored at the edge closing t+2. Its start bit is therefore due on `sdo` in cycle t+3, and the next 393 bits follow one per cycle. A frame queued behind another must start exactly 394 cycles after the one before it. The bench numbers every cycle and samples `sdo` at the falling edge. It records the cycle of each start bit and compares that cycle, and every frame bit, against values it rebuilds from the cycle numbers of the stimulus words and of the accept.

// File: rtl/drt_pkg.sv
package drt_pkg;
    localparam int NCH     = 16;
    localparam int NBIN    = 8;
    localparam int NSMP    = 3;
    localparam int TS_W    = 8;
    localparam int WORD_W  = NCH * NBIN;
    localparam int DATA_W  = NSMP * WORD_W;
    localparam int FRAME_W = 1 + TS_W + 1 + DATA_W;

    typedef logic [NCH-1:0][NBIN-1:0] word_t;

    typedef struct packed {
        logic [TS_W-1:0]     ts;
        word_t [NSMP-1:0]    smp;
    } evt_t;

    // MSB of the result leaves the serializer first.
    function automatic logic [FRAME_W-1:0] build_frame(evt_t e, logic err);
        logic [FRAME_W-1:0] f;
        f = '0;
        f[FRAME_W-1]          = 1'b1;
        f[FRAME_W-2 -: TS_W]  = e.ts;
        f[DATA_W]             = err;
        for (int ch = 0; ch < NCH; ch++)
            for (int s = 0; s < NSMP; s++)
                for (int b = 0; b < NBIN; b++)
                    f[DATA_W-1-(ch*NSMP*NBIN + s*NBIN + b)] = e.smp[s][ch][b];
        return f;
    endfunction
endpackage

// File: rtl/drt_sample_ring.sv
module drt_sample_ring
    import drt_pkg::*;
#(
    parameter int LAT_W = 8,
    parameter int AW    = LAT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  word_t              din,
    input  logic [LAT_W-1:0]   lat,
    output word_t [NSMP-1:0]   taps
);
    // One cycle of capture delay plus half the window behind the centre.
    localparam int BACK  = 1 + NSMP / 2;
    localparam int DEPTH = 2 ** AW;

    word_t            mem [DEPTH];
    logic [AW-1:0]    wp;

    always_ff @(posedge clk) begin
        if (rst) wp <= '0;
        else     wp <= wp + AW'(1);
    end

    always_ff @(posedge clk) begin
        mem[wp] <= din;
    end

    for (genvar s = 0; s < NSMP; s++) begin : g_tap
        logic [AW-1:0] addr;
        assign addr    = wp - AW'(lat) - AW'(BACK) + AW'(s);
        assign taps[s] = mem[addr];
    end
endmodule

// File: rtl/drt_event_fifo.sv
module drt_event_fifo
    import drt_pkg::*;
#(
    parameter int DEPTH = 13
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  evt_t  wdata,
    input  logic  pop,
    output evt_t  head,
    output logic  empty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    evt_t           mem [DEPTH];
    logic [PW-1:0]  wr, rd;
    logic [CW-1:0]  cnt;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr  <= '0;
            rd  <= '0;
            cnt <= '0;
        end else begin
            if (push) wr <= bump(wr);
            if (pop)  rd <= bump(rd);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr] <= wdata;
    end

    assign head  = mem[rd];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/drt_serializer.sv
module drt_serializer
    import drt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  evt_t  head,
    input  logic  empty,
    input  logic  err,
    output logic  pop,
    output logic  sdo
);
    localparam int CW = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh;
    logic [CW-1:0]      cnt;

    // Load when idle or while the final bit of the current frame is out.
    assign pop = !empty && (cnt <= CW'(1));
    assign sdo = sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (pop) begin
            sh  <= build_frame(head, err);
            cnt <= CW'(FRAME_W);
        end else if (cnt != '0) begin
            sh  <= {sh[FRAME_W-2:0], 1'b0};
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/drift_readout_core.sv
module drift_readout_core
    import drt_pkg::*;
#(
    parameter int LAT_W     = 8,
    parameter int EVT_DEPTH = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bcr,
    input  logic               l1a,
    input  logic [LAT_W-1:0]   lat,
    input  logic [WORD_W-1:0]  din,
    output logic               sdo
);
    logic [TS_W-1:0]   bc;
    logic              cap_v;
    logic [TS_W-1:0]   cap_ts;
    logic              ovf_q;
    logic              drop, push, pop;
    logic              fifo_full, fifo_empty;
    word_t [NSMP-1:0]  taps;
    evt_t              cap_evt, head;

    always_ff @(posedge clk) begin
        if (rst || bcr) bc <= '0;
        else            bc <= bc + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_v  <= 1'b0;
            cap_ts <= '0;
        end else begin
            cap_v  <= l1a;
            cap_ts <= bc;
        end
    end

    drt_sample_ring #(.LAT_W(LAT_W)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .din  (word_t'(din)),
        .lat  (lat),
        .taps (taps)
    );

    assign cap_evt.ts  = cap_ts;
    assign cap_evt.smp = taps;

    assign drop = cap_v && fifo_full && !pop;
    assign push = cap_v && !drop;

    drt_event_fifo #(.DEPTH(EVT_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (cap_evt),
        .pop   (pop),
        .head  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst)       ovf_q <= 1'b0;
        else if (drop) ovf_q <= 1'b1;
        else if (pop)  ovf_q <= 1'b0;
    end

    drt_serializer u_ser (
        .clk   (clk),
        .rst   (rst),
        .head  (head),
        .empty (fifo_empty),
        .err   (ovf_q),
        .pop   (pop),
        .sdo   (sdo)
    );
endmodule

// File: rtl/drift_readout_chk.sv
module drift_readout_chk
    import drt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bcr,
    input logic [7:0]  bc,
    input logic        cap_v,
    input logic        fifo_full,
    input logic        drop,
    input logic        pop,
    input logic        ovf_q,
    input logic        sdo,
    input logic [8:0]  ser_cnt
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R2: counter steps by one unless a bunch-counter reset preceded
    a_r2_bc_step: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(bcr)) |-> (bc == $past(bc) + 8'd1));

    // R2: bunch-counter reset forces zero
    a_r2_bc_clear: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(bcr)) |-> (bc == 8'd0));

    // R7: an event is never dropped while there is room
    a_r7_no_drop_with_room: assert property (@(posedge clk) disable iff (rst)
        (cap_v && !fifo_full) |-> !drop);

    // R8: a drop raises the overflow flag
    a_r8_drop_flags: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf_q);

    // R8: flag holds until a frame takes it
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !pop) |=> ovf_q);

    // R4: each load puts a start bit out next cycle
    a_r4_start_bit: assert property (@(posedge clk) disable iff (rst)
        pop |=> (sdo && ser_cnt == 9'(FRAME_W)));

    // R9: line is low when no frame is in flight
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        (ser_cnt == 9'd0) |-> !sdo);
endmodule

bind drift_readout_core drift_readout_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bcr       (bcr),
    .bc        (bc),
    .cap_v     (cap_v),
    .fifo_full (fifo_full),
    .drop      (drop),
    .pop       (pop),
    .ovf_q     (ovf_q),
    .sdo       (sdo),
    .ser_cnt   (u_ser.cnt)
);

// File: tb/tb_drift_readout_core.sv
`timescale 1ns/1ps
module tb_drift_readout_core;
    import drt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bcr = 1'b0;
    logic              l1a = 1'b0;
    logic [7:0]        lat = 8'd10;
    logic [WORD_W-1:0] din;
    logic              sdo;

    drift_readout_core dut (
        .clk (clk), .rst (rst), .bcr (bcr), .l1a (l1a),
        .lat (lat), .din (din), .sdo (sdo)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0, zero_cyc = 0;
    bit done = 1'b0;

    function automatic logic [7:0] wgen(int k, int ch);
        return 8'((k * 37 + ch * 11) ^ (k >> 2));
    endfunction

    always @(negedge clk)
        for (int ch = 0; ch < NCH; ch++) din[ch*NBIN +: NBIN] = wgen(cyc, ch);

    // Frame monitor: bit index 0 is the first bit on the line.
    logic [FRAME_W-1:0] frames [32];
    int                 fstart [32];
    int                 nfr = 0, idx = 0;
    bit                 inf = 1'b0;
    logic [FRAME_W-1:0] cur;

    always @(negedge clk) begin
        if (rst) inf = 1'b0;
        else if (!inf) begin
            if (sdo && nfr < 32) begin
                inf = 1'b1; cur = '0; cur[0] = 1'b1; idx = 1; fstart[nfr] = cyc;
            end
        end else begin
            cur[idx] = sdo;
            idx++;
            if (idx == FRAME_W) begin
                frames[nfr] = cur; nfr++; inf = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [FRAME_W-1:0] exp_frame(int t, int l, int ts, bit err);
        logic [FRAME_W-1:0] e;
        logic [7:0] tsb, w;
        e = '0; e[0] = 1'b1; tsb = 8'(ts);
        for (int i = 0; i < 8; i++) e[1+i] = tsb[7-i];
        e[9] = err;
        for (int ch = 0; ch < NCH; ch++)
            for (int s = 0; s < NSMP; s++) begin
                w = wgen(t - l - 1 + s, ch);
                for (int b = 0; b < NBIN; b++) e[10 + ch*NSMP*NBIN + s*NBIN + b] = w[b];
            end
        return e;
    endfunction

    task automatic cmp_frame(int n, int t, int l, int ts, bit err, string req);
        logic [FRAME_W-1:0] e;
        int bad;
        e = exp_frame(t, l, ts, err);
        bad = -1;
        for (int i = FRAME_W - 1; i >= 0; i--) if (frames[n][i] !== e[i]) bad = i;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, $sformatf("%s frame %0d bit %0d", req, n, bad),
                   longint'(frames[n][bad]), longint'(e[bad]));
    endtask

    task automatic wait_frames(int n);
        int g = 0;
        while (nfr < n && g < 8000) begin @(negedge clk); g++; end
    endtask

    task automatic fire(input int l, output int t, output int ts);
        @(negedge clk);
        lat = 8'(l); l1a = 1'b1; t = cyc; ts = (t - zero_cyc) & 255;
        @(negedge clk);
        l1a = 1'b0;
    endtask

    task automatic t_reset();
        int highs = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(sdo == 1'b0, "R1 sdo during reset", sdo, 0);
        rst = 1'b0; zero_cyc = cyc;
        @(negedge clk);
        check(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
        repeat (300) begin @(negedge clk); if (sdo) highs++; end
        check(highs == 0, "R9 idle line", highs, 0);
    endtask

    task automatic t_single(int l, bit exp_err, string req);
        int n0, t, ts;
        n0 = nfr;
        fire(l, t, ts);
        wait_frames(n0 + 1);
        check(nfr == n0 + 1, {req, " R5 frame count"}, nfr, n0 + 1);
        check(fstart[n0] == t + 3, {req, " R5 start cycle"}, fstart[n0], t + 3);
        cmp_frame(n0, t, l, ts, exp_err, {req, " R4 content"});
        check(frames[n0][9] == exp_err, "R8 error bit", frames[n0][9], exp_err);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_bcr();
        int c;
        @(negedge clk); bcr = 1'b1; c = cyc;
        @(negedge clk); bcr = 1'b0; zero_cyc = c + 1;
        repeat (6) @(negedge clk);
        t_single(33, 1'b0, "R2 after bcr");
        repeat (280) @(negedge clk);
        t_single(7, 1'b0, "R2 wrapped stamp");
    endtask

    task automatic t_b2b();
        int n0, t1, s1, t2, s2;
        n0 = nfr;
        fire(40, t1, s1);
        fire(41, t2, s2);
        wait_frames(n0 + 2);
        check(nfr == n0 + 2, "R6 two frames", nfr, n0 + 2);
        check(fstart[n0+1] == fstart[n0] + FRAME_W, "R6 no gap", fstart[n0+1], fstart[n0] + FRAME_W);
        cmp_frame(n0, t1, 40, s1, 1'b0, "R3 first of pair");
        cmp_frame(n0 + 1, t2, 41, s2, 1'b0, "R3 second of pair");
        repeat (5) @(negedge clk);
    endtask

    task automatic t_overflow();
        int n0, highs;
        int tt [15];
        int ss [15];
        n0 = nfr;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            lat = 8'd20; l1a = 1'b1; tt[k] = cyc; ss[k] = (cyc - zero_cyc) & 255;
        end
        @(negedge clk); l1a = 1'b0;
        wait_frames(n0 + 14);
        highs = 0;
        repeat (FRAME_W + 20) begin @(negedge clk); if (sdo) highs++; end
        check(nfr == n0 + 14, "R7 dropped event not sent", nfr, n0 + 14);
        check(highs == 0, "R9 idle after drain", highs, 0);
        for (int k = 0; k < 14; k++) begin
            cmp_frame(n0 + k, tt[k], 20, ss[k], k == 1, "R7 R8 burst frame");
            if (k > 0)
                check(fstart[n0+k] == fstart[n0+k-1] + FRAME_W, "R6 burst spacing",
                      fstart[n0+k], fstart[n0+k-1] + FRAME_W);
        end
    endtask

    initial begin
        t_reset();
        t_single(10, 1'b0, "R3 lat 10");
        t_single(1, 1'b0, "R3 lat 1");
        t_single(255, 1'b0, "R3 lat 255");
        t_bcr();
        t_b2b();
        t_overflow();
        t_single(12, 1'b0, "R8 flag cleared");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: run hung, actual %0d expected 1", done);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule